// File: doc/BRIEF.md
# Sum-to-Booth direct recoder

This block takes two two's-complement operands of equal width and produces the radix-4 signed-digit (modified Booth) form of their sum. It never forms the sum as a binary word. A multiplier that has to compute X·(A+B) can feed these digits straight to its partial-product selectors, so the carry-propagate adder that would normally sit in front of the Booth encoder is removed.

The block is a chain of identical recoding cells. Each cell takes two bits of each operand and uses adders whose inputs and outputs may carry negative weight: a half adder with a negatively weighted sum, a half adder with one negative input, and a conventional full adder. Each cell passes two bits to its upper neighbour and nothing further up the chain, so the logic depth does not depend on the operand width.

Both odd and even operand widths are accepted through the parameter `W`. Each operand is sign-extended to the next even width at or above W+1 bits, which gives W/2+1 digits (integer division). Each digit leaves the block as a sign/one/two triple. The triples are registered, so they appear one clock after the operands are presented.

Top module: `sum_booth_recoder`

## Requirements
- R1: One clock edge after the operands are sampled, the sum over j of d_j·4^j equals the signed value A+B, where d_j is the value of digit j. This holds for every operand pair, including both operands at their most negative value, for odd and even W. There are W/2+1 digits (integer division).
- R2: Digit j is encoded on bits j of the outputs. one_o[j]=1 means magnitude 1, two_o[j]=1 means magnitude 2, and both low means magnitude 0. one_o[j] and two_o[j] are never both high. neg_o[j]=1 makes the digit negative and is low whenever the magnitude is 0.
- R3: Digit j depends only on operand bits at positions 2j-3 through 2j+1, counted after sign extension. Changing any other operand bit leaves digit j unchanged.
- R4: For even W, the most significant digit lies in {-1, 0, +1}, so two_o[W/2] stays low.
- R5: While rst_ni is low, neg_o, one_o and two_o are all zero, whatever the operands are.
- R6: The digits presented after an edge reflect the operands sampled at that edge. A change of the operands between edges does not reach the outputs before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | W | First two's-complement operand |
| b_i | input | W | Second two's-complement operand |
| neg_o | output | W/2+1 | Per-digit sign, high for a negative digit |
| one_o | output | W/2+1 | Per-digit flag for magnitude 1 |
| two_o | output | W/2+1 | Per-digit flag for magnitude 2 |

## Verification
The assertions assume that a_i and b_i carry known values, with no X or Z, at every rising edge after reset is released. They also assume that the outputs are compared with the operands sampled exactly one edge earlier, and only after at least one edge has passed with reset high. The stimulus keeps within these assumptions. It changes the operands only on falling edges, drives only defined values, and starts the exhaustive sweep after reset has been released on a falling edge. The locality property is compared between operand pairs that differ only outside a digit's bit window, and each such pair is presented as a fully defined input.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [0:0] {
    SHA_POS_POS = 1'b0,  // 2c - s =  p + q
    SHA_NEG_POS = 1'b1   // 2c - s = -p + q
  } sha_kind_e;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdigit_t;

  function automatic int unsigned digit_count(input int unsigned width);
    return width / 2 + 1;
  endfunction

endpackage

// File: rtl/sbr_signed_ha.sv
module sbr_signed_ha
  import sbr_pkg::*;
#(
  parameter sha_kind_e KIND = SHA_POS_POS
) (
  input  logic p_i,
  input  logic q_i,
  output logic c_o,
  output logic s_o
);

  // Sum output always carries negative weight.
  if (KIND == SHA_POS_POS) begin : g_pos_pos
    assign c_o = p_i | q_i;
    assign s_o = p_i ^ q_i;
  end else begin : g_neg_pos
    assign c_o = q_i & ~p_i;
    assign s_o = p_i ^ q_i;
  end

endmodule

// File: rtl/sbr_full_adder.sv
module sbr_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic c_o,
  output logic s_o
);

  assign s_o = a_i ^ b_i ^ c_i;
  assign c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);

endmodule

// File: rtl/sbr_digit_enc.sv
module sbr_digit_enc
  import sbr_pkg::*;
(
  input  logic    hi_i,   // weight -2
  input  logic    mid_i,  // weight +1
  input  logic    lo_i,   // weight +1
  output bdigit_t digit_o
);

  assign digit_o.neg = hi_i & ~(mid_i & lo_i);
  assign digit_o.one = mid_i ^ lo_i;
  assign digit_o.two = hi_i ? (~mid_i & ~lo_i) : (mid_i & lo_i);

endmodule

// File: rtl/sbr_cell.sv
module sbr_cell
  import sbr_pkg::*;
(
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  input  logic       xfer_i,  // transfer from lower cell, weight 4^j
  input  logic       bdig_i,  // low digit bit from lower cell, weight 4^j
  output logic       xfer_o,
  output logic       bdig_o,
  output bdigit_t    digit_o
);

  logic s_odd;
  logic f_even;
  logic g_even;
  logic s_top;

  // Odd position: a1+b1 = 2*xfer - s_odd; xfer depends on local bits only.
  sbr_signed_ha #(.KIND(SHA_POS_POS)) u_odd_ha (
    .p_i(a_i[1]),
    .q_i(b_i[1]),
    .c_o(xfer_o),
    .s_o(s_odd)
  );

  // Even position absorbs the incoming transfer.
  sbr_full_adder u_even_fa (
    .a_i(a_i[0]),
    .b_i(b_i[0]),
    .c_i(xfer_i),
    .c_o(f_even),
    .s_o(g_even)
  );

  // Odd position again: f_even - s_odd = 2*bdig - s_top.
  sbr_signed_ha #(.KIND(SHA_NEG_POS)) u_mix_ha (
    .p_i(s_odd),
    .q_i(f_even),
    .c_o(bdig_o),
    .s_o(s_top)
  );

  sbr_digit_enc u_enc (
    .hi_i   (s_top),
    .mid_i  (g_even),
    .lo_i   (bdig_i),
    .digit_o(digit_o)
  );

endmodule

// File: rtl/sum_booth_recoder.sv
module sum_booth_recoder
  import sbr_pkg::*;
#(
  parameter  int unsigned W  = 8,
  localparam int unsigned ND = digit_count(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [ND-1:0] neg_o,
  output logic [ND-1:0] one_o,
  output logic [ND-1:0] two_o
);

  localparam int unsigned EW = 2 * ND;

  logic [EW-1:0]          a_ext;
  logic [EW-1:0]          b_ext;
  logic [ND:0]            xfer;
  logic [ND:0]            bdig;
  bdigit_t [ND-1:0]       dig_d;
  logic [1:0]             top_carry_unused;

  assign a_ext = {{(EW - W){a_i[W-1]}}, a_i};
  assign b_ext = {{(EW - W){b_i[W-1]}}, b_i};

  assign xfer[0] = 1'b0;
  assign bdig[0] = 1'b0;

  for (genvar j = 0; j < ND; j++) begin : g_cell
    sbr_cell u_cell (
      .a_i    (a_ext[2*j+1:2*j]),
      .b_i    (b_ext[2*j+1:2*j]),
      .xfer_i (xfer[j]),
      .bdig_i (bdig[j]),
      .xfer_o (xfer[j+1]),
      .bdig_o (bdig[j+1]),
      .digit_o(dig_d[j])
    );
  end

  // Top cell only ever sees sign copies; its outgoing bits are implied by them.
  assign top_carry_unused = {xfer[ND], bdig[ND]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_o <= '0;
      one_o <= '0;
      two_o <= '0;
    end else begin
      for (int j = 0; j < ND; j++) begin
        neg_o[j] <= dig_d[j].neg;
        one_o[j] <= dig_d[j].one;
        two_o[j] <= dig_d[j].two;
      end
    end
  end

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter  int unsigned W  = 8,
  localparam int unsigned ND = W / 2 + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic [ND-1:0] neg_o,
  input logic [ND-1:0] one_o,
  input logic [ND-1:0] two_o
);

  localparam int unsigned VW = 2 * ND + 2;

  logic                 primed_q;
  logic signed [VW-1:0] dec_val;
  logic signed [VW-1:0] opnd_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  always_comb begin
    dec_val = '0;
    for (int j = 0; j < ND; j++) begin
      logic signed [VW-1:0] mag;
      mag = two_o[j] ? VW'(2) : (one_o[j] ? VW'(1) : VW'(0));
      dec_val = dec_val + ((neg_o[j] ? -mag : mag) <<< (2 * j));
    end
  end

  assign opnd_sum = VW'(signed'(a_i)) + VW'(signed'(b_i));

  assert_sum_identity_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> (dec_val == $past(opnd_sum)));

  assert_reset_clear_R5: assert property (@(posedge clk_i)
    !rst_ni |-> (neg_o == '0 && one_o == '0 && two_o == '0));

  for (genvar j = 0; j < ND; j++) begin : g_dig
    assert_mag_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({one_o[j], two_o[j]}));
    assert_sign_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      neg_o[j] |-> (one_o[j] | two_o[j]));
  end

  if (W % 2 == 0) begin : g_even
    assert_top_small_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !two_o[ND-1]);
  end

endmodule

bind sum_booth_recoder sbr_checker #(.W(W)) u_sbr_checker (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .a_i   (a_i),
  .b_i   (b_i),
  .neg_o (neg_o),
  .one_o (one_o),
  .two_o (two_o)
);

// File: tb/sum_booth_recoder_bench.sv
module sum_booth_recoder_bench;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic [5:0] a6 = '0, b6 = '0;
  logic [4:0] a5 = '0, b5 = '0;
  logic [3:0] neg6, one6, two6;
  logic [2:0] neg5, one5, two5;
  logic [11:0] dig6 [4096];
  int n_cmp = 0;
  int n_bad = 0;

  always #2ns clk = ~clk;

  sum_booth_recoder #(.W(6)) u_sum_booth_recoder (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a6), .b_i(b6),
    .neg_o(neg6), .one_o(one6), .two_o(two6));

  sum_booth_recoder #(.W(5)) u_sum_booth_recoder_odd (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a5), .b_i(b5),
    .neg_o(neg5), .one_o(one5), .two_o(two5));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dval(input logic n, input logic o, input logic t);
    int m;
    m = t ? 2 : (o ? 1 : 0);
    return n ? -m : m;
  endfunction

  function automatic int sum6();
    int s = 0;
    for (int j = 0; j < 4; j++) s += dval(neg6[j], one6[j], two6[j]) * (4 ** j);
    return s;
  endfunction

  function automatic int sum5();
    int s = 0;
    for (int j = 0; j < 3; j++) s += dval(neg5[j], one5[j], two5[j]) * (4 ** j);
    return s;
  endfunction

  task automatic chk_enc_R2();
    for (int j = 0; j < 4; j++) begin
      chk(!(one6[j] && two6[j]), "R2 even one/two exclusive", {one6[j], two6[j]}, 0);
      chk(!neg6[j] || one6[j] || two6[j], "R2 even sign on zero", neg6[j], 0);
    end
    for (int j = 0; j < 3; j++) begin
      chk(!(one5[j] && two5[j]), "R2 odd one/two exclusive", {one5[j], two5[j]}, 0);
      chk(!neg5[j] || one5[j] || two5[j], "R2 odd sign on zero", neg5[j], 0);
    end
  endtask

  task automatic apply(input logic [5:0] xa6, input logic [5:0] xb6,
                       input logic [4:0] xa5, input logic [4:0] xb5);
    @(negedge clk);
    a6 = xa6; b6 = xb6; a5 = xa5; b5 = xb5;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired: cycles=%0d expected<%0d", 150000, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    #1ns rst_ni = 1'b0;
    a6 = 6'h2b; b6 = 6'h3f; a5 = 5'h1f; b5 = 5'h11;
    repeat (3) @(negedge clk);
    // R5: outputs cleared while reset is held
    chk(neg6 == 0 && one6 == 0 && two6 == 0, "R5 even reset state",
        {neg6, one6, two6}, 0);
    chk(neg5 == 0 && one5 == 0 && two5 == 0, "R5 odd reset state",
        {neg5, one5, two5}, 0);
    rst_ni = 1'b1;

    // R6: output follows the sampled edge, not the live input
    apply(6'd7, 6'd9, 5'd3, 5'd4);
    chk(sum6() == 16, "R6 even first capture", sum6(), 16);
    a6 = 6'd20; b6 = 6'd1; a5 = 5'd2; b5 = 5'd2;
    #1ns;
    chk(sum6() == 16, "R6 even held before edge", sum6(), 16);
    chk(sum5() == 7, "R6 odd held before edge", sum5(), 7);
    @(negedge clk);
    chk(sum6() == 21, "R6 even after edge", sum6(), 21);
    chk(sum5() == 4, "R6 odd after edge", sum5(), 4);

    // Corners: most negative pairs and all-ones pairs
    apply(6'h20, 6'h20, 5'h10, 5'h10);
    chk(sum6() == -64, "R1 even most negative", sum6(), -64);
    chk(sum5() == -32, "R1 odd most negative", sum5(), -32);
    apply(6'h1f, 6'h1f, 5'h0f, 5'h0f);
    chk(sum6() == 62, "R1 even largest", sum6(), 62);
    chk(sum5() == 30, "R1 odd largest", sum5(), 30);

    // Exhaustive sweep (W=6 fully, W=5 fully within it)
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] iv;
      int e6, e5;
      iv = 12'(i);
      apply(iv[11:6], iv[5:0], iv[9:5], iv[4:0]);
      e6 = int'($signed(iv[11:6])) + int'($signed(iv[5:0]));
      e5 = int'($signed(iv[9:5])) + int'($signed(iv[4:0]));
      chk(sum6() == e6, "R1 even sum identity", sum6(), e6);
      chk(sum5() == e5, "R1 odd sum identity", sum5(), e5);
      chk_enc_R2();
      chk(!two6[3], "R4 even top digit small", dval(neg6[3], one6[3], two6[3]), 0);
      dig6[i] = {neg6, one6, two6};
    end

    // R3: digit j unaffected by bits outside positions 2j-3..2j+1
    for (int i = 0; i < 4096; i++) begin
      for (int j = 0; j < 4; j++) begin
        logic [5:0] m;
        logic [11:0] k;
        m = '0;
        for (int p = 0; p < 6; p++) if (p >= 2*j - 3 && p <= 2*j + 1) m[p] = 1'b1;
        k = {12'(i) >> 6 & 12'(m)} << 6 | (12'(i) & 12'(m));
        chk({dig6[i][8+j], dig6[i][4+j], dig6[i][j]} ==
            {dig6[k][8+j], dig6[k][4+j], dig6[k][j]}, "R3 digit locality",
            {dig6[i][8+j], dig6[i][4+j], dig6[i][j]},
            {dig6[k][8+j], dig6[k][4+j], dig6[k][j]});
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule